// File: doc/BRIEF.md
# AC97 Slot Receive FIFO Controller

This block takes the per-slot sample stream of an AC97-style audio frame, after the serial link has been deserialized, and keeps the samples from software-selected slots. It stores them in an eight-word receive FIFO. A single 16-bit control/status register sets the source. A 4-bit slot code picks slot N, and a mono/stereo bit picks either that slot alone or the adjacent pair N and N+1. Software reads captured words through a pop port that shows the oldest word.

A level-sensitive interrupt is raised while the FIFO holds more words than a 3-bit threshold field, so the trigger level can be set anywhere from 1 to 8 words. The same register reports full and empty as live status and keeps a sticky overflow flag. That flag is set when a sample is lost to a full FIFO and is cleared by writing one to it. A stored DMA enable bit is combined with "not empty" to form a request qualifier for an external transfer engine.

Top module: `ac97_slot_rx_ctrl`

## Requirements
- R1: After reset the FIFO is empty, all control fields are 0, overflow is clear, irq and dma_req are low, and the register reads 0x4000.
- R2: With bit 3 = 0 (mono) and slot code N in bits 7:4, where N is 3 to 12, only samples whose slot_num equals N are pushed. All other slots are ignored.
- R3: With bit 3 = 1 (stereo) and N from 3 to 11, samples of slot N and slot N+1 are pushed, with slot N's word leaving the FIFO first.
- R4: Codes 0 to 2 and 13 to 15 in either mode, and code 12 in stereo mode, capture nothing.
- R5: irq is high exactly while the word count is at least T+1, where T is bits 10:8. It falls as soon as pops take the count below T+1.
- R6: Bit 13 reads 1 while the FIFO holds 8 words, and bit 14 reads 1 while it holds none. Writes to these bits have no effect.
- R7: A sample that arrives while the FIFO is full, with no pop in the same cycle, is discarded, leaves the stored words unchanged and sets bit 15. Bit 15 stays set until a write with bit 15 = 1 clears it. A write with bit 15 = 0 leaves it set.
- R8: dma_req equals bit 11 AND (FIFO not empty).
- R9: Bits 3, 7:4, 10:8 and 11 read back the last written value. Bits 2:0 and 12 always read 0.
- R10: pop_data shows the oldest stored word. A pop removes it. A pop on an empty FIFO changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_valid | input | 1 | One-cycle strobe: a slot sample is present |
| slot_num | input | 4 | Slot number of the present sample |
| slot_data | input | 20 | Sample data |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Control/status register read value |
| pop | input | 1 | Remove the oldest FIFO word |
| pop_data | output | 20 | Oldest FIFO word |
| irq | output | 1 | Level-sensitive fill threshold interrupt |
| dma_req | output | 1 | DMA enable AND FIFO not empty |

## Verification
The bench drives whole frames of slots 0 to 12 and checks that the right slots land in the FIFO. A decoder that is off by one slot, or that puts the stereo pair in the wrong order, pops the wrong data. The reserved codes and the stereo code 12 must leave the FIFO empty. A design that accepts code 12 in stereo would capture slot 12, or even slot 13. The threshold is tested at its top setting by filling to seven and then eight words. An overflow push must leave the oldest data intact, and the flag must survive a write of zero to bit 15. A design that overwrote a stored word, or cleared the flag on any write, would pop altered data or read the flag back as 0. A pop on an empty FIFO must not disturb the pointers, which later pops would otherwise expose.

// File: rtl/ac97_rx_pkg.sv
package ac97_rx_pkg;
  localparam int SLOT_W   = 4;
  localparam int THR_W    = 3;
  localparam int REG_W    = 16;
  // register bit positions
  localparam int B_STEREO = 3;
  localparam int B_CODE   = 4;
  localparam int B_THR    = 8;
  localparam int B_DMA    = 11;
  localparam int B_FULL   = 13;
  localparam int B_EMPTY  = 14;
  localparam int B_OVF    = 15;

  typedef struct packed {
    logic              dma_en;
    logic [THR_W-1:0]  thr;
    logic [SLOT_W-1:0] code;
    logic              stereo;
  } rx_cfg_t;
endpackage

// File: rtl/ac97_slot_match.sv
module ac97_slot_match
  import ac97_rx_pkg::*;
#(
  parameter int MIN_SLOT = 3,
  parameter int MAX_SLOT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [SLOT_W-1:0] code,
  input  logic              stereo,
  output logic              hit
);
  logic legal;
  logic lo_hit, hi_hit;

  always_comb begin
    legal  = (code >= SLOT_W'(MIN_SLOT)) && (code <= SLOT_W'(MAX_SLOT)) &&
             !(stereo && (code == SLOT_W'(MAX_SLOT)));
    lo_hit = (slot_num == code);
    hi_hit = stereo && (slot_num == code + SLOT_W'(1));
    hit    = valid && legal && (lo_hit || hi_hit);
  end

  // R4: out-of-range codes never capture
  assert_reserved_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ((code < SLOT_W'(MIN_SLOT)) || (code > SLOT_W'(MAX_SLOT)))) |-> !hit);
endmodule

// File: rtl/ac97_rx_fifo.sv
module ac97_rx_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] count_d;
  logic          do_push, do_pop;

  always_comb begin
    full     = (count == CW'(DEPTH));
    empty    = (count == '0);
    do_pop   = pop && !empty;
    do_push  = push && (!full || do_pop);
    drop     = push && full && !pop;
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (do_push) wr_ptr_d = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
    if (do_pop)  rd_ptr_d = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
    if (do_push && !do_pop) count_d = count + CW'(1);
    else if (do_pop && !do_push) count_d = count - CW'(1);
    rdata    = mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  // R7: a rejected push leaves the fill level untouched
  assert_drop_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (count == CW'(DEPTH)));
  // R6: full and empty never both true
  assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R10: a pop on empty changes nothing without a push
  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/ac97_rx_csr.sv
module ac97_rx_csr
  import ac97_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             drop,
  output rx_cfg_t          cfg,
  output logic             ovf
);
  rx_cfg_t cfg_d;
  logic    ovf_d;
  logic    clr;

  always_comb begin
    clr   = wr && wdata[B_OVF];
    cfg_d = cfg;
    if (wr) begin
      cfg_d.stereo = wdata[B_STEREO];
      cfg_d.code   = wdata[B_CODE +: SLOT_W];
      cfg_d.thr    = wdata[B_THR +: THR_W];
      cfg_d.dma_en = wdata[B_DMA];
    end
    // set wins over a same-cycle clear
    ovf_d = drop ? 1'b1 : (clr ? 1'b0 : ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      ovf <= 1'b0;
    end else begin
      cfg <= cfg_d;
      ovf <= ovf_d;
    end
  end

  // R7: flag only leaves through a write-one
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr && wdata[B_OVF])) |=> ovf);
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);
endmodule

// File: rtl/ac97_slot_rx_ctrl.sv
module ac97_slot_rx_ctrl
  import ac97_rx_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_valid,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [DATA_W-1:0] slot_data,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              irq,
  output logic              dma_req
);
  localparam int CW = $clog2(DEPTH+1);

  logic          rst_s1, rst_sync_n;
  rx_cfg_t       cfg;
  logic          ovf, hit, full, empty, drop;
  logic [CW-1:0] count;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  ac97_slot_match u_match (
    .clk(clk), .rst_n(rst_sync_n), .valid(slot_valid), .slot_num(slot_num),
    .code(cfg.code), .stereo(cfg.stereo), .hit(hit)
  );

  ac97_rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(hit), .wdata(slot_data), .pop(pop),
    .rdata(pop_data), .count(count), .full(full), .empty(empty), .drop(drop)
  );

  ac97_rx_csr u_csr (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .wdata(reg_wdata),
    .drop(drop), .cfg(cfg), .ovf(ovf)
  );

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[2:0], reg_wdata[12], reg_wdata[14:13]};

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[B_STEREO]            = cfg.stereo;
    reg_rdata[B_CODE +: SLOT_W]    = cfg.code;
    reg_rdata[B_THR +: THR_W]      = cfg.thr;
    reg_rdata[B_DMA]               = cfg.dma_en;
    reg_rdata[B_FULL]              = full;
    reg_rdata[B_EMPTY]             = empty;
    reg_rdata[B_OVF]               = ovf;
    irq                            = (count > CW'(cfg.thr));
    dma_req                        = cfg.dma_en && !empty;
  end

  // R5: the interrupt never stands over an empty FIFO
  assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> !empty);
  // R8: no request without the enable
  assert_dma_gated_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg.dma_en |-> !dma_req);
endmodule

// File: tb/ac97_slot_rx_ctrl_tb.sv
module ac97_slot_rx_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_valid;
  logic [3:0]  slot_num;
  logic [19:0] slot_data;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        pop;
  logic [19:0] pop_data;
  logic        irq, dma_req;

  int errors = 0;
  int checks = 0;

  // bench model of the register and FIFO
  logic [19:0] mq[$];
  logic        m_stereo, m_dma, m_ovf;
  logic [3:0]  m_code;
  logic [2:0]  m_thr;

  always #5 clk = ~clk;

  ac97_slot_rx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_num(slot_num),
    .slot_data(slot_data), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pop(pop), .pop_data(pop_data), .irq(irq),
    .dma_req(dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg();
    logic [15:0] v = '0;
    v[3] = m_stereo; v[7:4] = m_code; v[10:8] = m_thr; v[11] = m_dma;
    v[13] = (mq.size() == 8); v[14] = (mq.size() == 0); v[15] = m_ovf;
    return v;
  endfunction

  task automatic chk_status(input string req);
    chk({req, " reg"}, {16'h0, reg_rdata}, {16'h0, exp_reg()});
    chk({req, " irq"}, {31'h0, irq}, {31'h0, (mq.size() > int'(m_thr))});
    chk({req, " dma_req"}, {31'h0, dma_req}, {31'h0, m_dma && (mq.size() != 0)});
  endtask

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    m_stereo = v[3]; m_code = v[7:4]; m_thr = v[10:8]; m_dma = v[11];
    if (v[15]) m_ovf = 1'b0;
  endtask

  // driver: sends one slot and queues what should be captured
  task automatic send(input int s, input logic [19:0] d);
    bit legal, hitm;
    @(negedge clk);
    slot_valid = 1'b1; slot_num = 4'(s); slot_data = d;
    legal = (m_code >= 3) && (m_code <= 12) && !(m_stereo && m_code == 12);
    hitm  = legal && ((s == int'(m_code)) || (m_stereo && s == int'(m_code) + 1));
    @(negedge clk);
    slot_valid = 1'b0;
    if (hitm) begin
      if (mq.size() < 8) mq.push_back(d);
      else m_ovf = 1'b1;
    end
  endtask

  task automatic frame(input logic [19:0] base);
    for (int s = 0; s < 13; s++) send(s, base + 20'(s));
  endtask

  // monitor: compares the head against the scoreboard and pops
  task automatic take(input string req);
    @(negedge clk);
    if (mq.size() != 0) begin
      chk({req, " pop_data"}, {12'h0, pop_data}, {12'h0, mq[0]});
      void'(mq.pop_front());
    end
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; slot_valid = 1'b0; slot_num = '0; slot_data = '0;
    reg_wr = 1'b0; reg_wdata = '0; pop = 1'b0;
    m_stereo = 0; m_dma = 0; m_ovf = 0; m_code = 0; m_thr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset reg", {16'h0, reg_rdata}, 32'h4000);
    chk_status("R1");

    // R9: readback, bits 2:0, 12, 13, 14 ignored
    write_reg(16'h7A5F);
    chk("R9 readback", {16'h0, reg_rdata}, 32'h4A58);
    chk_status("R9");

    // R10: pop on empty changes nothing
    take("R10 empty pop");
    chk_status("R10 empty pop");

    // R2: mono slot 5
    write_reg(16'h0050);
    frame(20'h10000);
    chk_status("R2");
    take("R2");
    chk_status("R2 drained");

    // R3 + R8: stereo slots 3/4, thr 1, dma on
    write_reg(16'h0938);
    frame(20'h20000);
    chk_status("R3 R8");
    take("R3 lower first");
    chk_status("R5 below thr");
    take("R3 upper");
    chk_status("R8 empty");

    // R3: stereo upper boundary 11/12
    write_reg(16'h00B8);
    frame(20'h30000);
    chk_status("R3 11/12");
    take("R3 slot11"); take("R3 slot12");

    // R4: reserved codes and stereo 12
    write_reg(16'h0010); frame(20'h40000); chk_status("R4 code1");
    write_reg(16'h00D0); frame(20'h41000); chk_status("R4 code13");
    write_reg(16'h00F8); frame(20'h42000); chk_status("R4 code15 stereo");
    write_reg(16'h00C8); frame(20'h43000); chk_status("R4 stereo12");
    // R2: mono 12 is legal
    write_reg(16'h00C0); frame(20'h44000); chk_status("R2 mono12");
    take("R2 mono12");

    // R5/R6/R7: thr 7, mono slot 4
    write_reg(16'h0740);
    for (int i = 0; i < 7; i++) send(4, 20'h50000 + 20'(i));
    chk_status("R5 seven words");
    send(4, 20'h50007);
    chk_status("R5 R6 full");
    send(4, 20'h5DEAD);
    chk_status("R7 overflow");
    take("R7 head kept");
    chk_status("R5 fell");
    write_reg(16'h0740);
    chk_status("R7 zero write keeps");
    write_reg(16'h8740);
    chk_status("R7 cleared");
    for (int i = 0; i < 7; i++) take("R7 order");
    chk_status("R6 empty");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule